// File: doc/BRIEF.md
# Receive Elastic Buffer with Programmable Alignment Delay

This block absorbs the phase and small frequency differences between a recovered receive clock and the local system clock. Words arrive on the write side under the recovered clock whenever the valid strobe is high. They leave on the read side under the system clock, one per cycle, in the order they arrived. The storage holds 2^AW words. The usual sizes are AW=6, which gives 64 words, and AW=4, which gives 16 words.

The fill level at which reading starts is not fixed at half the depth. Software chooses it through a delay field that is AW bits wide. The field is latched only when a resync pulse arrives. A resync resets both pointers. It holds the read side idle until the write side has advanced by the latched delay, and then it releases the stream. Words in flight when the resync arrives may be lost. A resync is expected after every change of line rate. Read and write positions cross between the clock domains as Gray code through two-flop synchronizers. A sticky error flag records an overflow or an underflow. While the flag is set, every output word is marked invalid until the next resync.

Top module: `rx_elastic_buf`

## Requirements
- R1: After reset, rd_valid_o and err_o are 0 and the latched delay is 0. The read side then starts as soon as the first word is visible, with no resync needed.
- R2: While err_o is low, each word accepted on the write side appears once at rd_data_o with rd_valid_o high, in arrival order, with no gaps.
- R3: A change on delay_i has no effect on latency until resync_i is sampled high. After a resync, the steady lag between the newest written word and the word being read grows by exactly the increase in the latched delay.
- R4: In the cycle after resync_i is sampled, rd_valid_o is 0. It stays 0 until the write position, as seen in the read domain, is ahead of the read position by at least max(delay, 1). At the first valid word, the lag is at least the latched delay.
- R5: If the read side finds the buffer empty while streaming (underflow), err_o goes to 1 and stays at 1. rd_valid_o stays 0 even when new data arrives, until a resync.
- R6: A write into a full buffer is dropped and sets err_o. No valid word with a gap in sequence leaves the buffer.
- R7: A sampled resync_i clears err_o on the next read clock edge and restarts the stream.
- R8: After the write clock rate changes, a resync restores a continuous valid stream.
- R9: Each registered pointer crosses the clock boundary as Gray code. It changes by at most one bit per cycle, except on the cycle after it is reset by a resync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered receive clock |
| rd_clk_i | input | 1 | Local system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe, one word per wr_clk_i cycle |
| wr_data_i | input | DW | Word to store |
| delay_i | input | AW | Alignment delay, latched on resync |
| resync_i | input | 1 | Realignment request, read clock domain |
| rd_data_o | output | DW | Word leaving the buffer |
| rd_valid_o | output | 1 | rd_data_o holds a valid word |
| err_o | output | 1 | Sticky overflow or underflow flag |

## Verification
Overflow is the hardest condition to reach, because the read side drains one word every cycle and equal clocks never fill the buffer. The bench therefore shortens the write clock period in the middle of a run until the write side runs into a full buffer. It then restores the period and issues a resync, which also covers the rate-change case. The effect of the delay is measured at the ports as the difference between the last word sent and the word being read. The bench compares that lag before and after the delay field changes, both without a resync and with one.

// File: rtl/rxeb_pkg.sv
`timescale 1ns/1ps
package rxeb_pkg;
  typedef enum logic [1:0] {
    RD_WAIT = 2'd0,  // waiting for the write side to confirm its restart
    RD_FILL = 2'd1,  // waiting until the fill level reaches the delay
    RD_RUN  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/rxeb_sync.sv
`timescale 1ns/1ps
module rxeb_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rxeb_ram.sv
`timescale 1ns/1ps
module rxeb_ram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/rxeb_wr_ctl.sv
`timescale 1ns/1ps
module rxeb_wr_ctl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          req_tgl_i,
  input  logic [AW:0]   rd_gray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wr_gray_o,
  output logic          ack_tgl_o,
  output logic          ovf_o,
  output logic          restart_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] ptr_q, ptr_n, rd_bin;
  logic          req_q, guard_q, full;

  always_comb begin
    for (int i = 0; i < PW; i++) rd_bin[i] = ^(rd_gray_i >> i);
  end

  assign restart_o = req_tgl_i ^ req_q;
  assign full      = (ptr_q[AW] != rd_bin[AW]) && (ptr_q[AW-1:0] == rd_bin[AW-1:0]);
  // while guarded the synchronized read pointer may still be stale
  assign we_o      = valid_i && !restart_o && !(full && !guard_q);
  assign waddr_o   = ptr_q[AW-1:0];

  always_comb begin
    ptr_n = ptr_q;
    if (restart_o) ptr_n = '0;
    else if (we_o) ptr_n = ptr_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      wr_gray_o <= '0;
      req_q     <= 1'b0;
      ack_tgl_o <= 1'b0;
      ovf_o     <= 1'b0;
      guard_q   <= 1'b0;
    end else begin
      ptr_q     <= ptr_n;
      wr_gray_o <= ptr_n ^ (ptr_n >> 1);
      req_q     <= req_tgl_i;
      if (restart_o) begin
        ack_tgl_o <= ~ack_tgl_o;
        ovf_o     <= 1'b0;
        guard_q   <= 1'b1;
      end else begin
        if (guard_q && rd_bin == '0) guard_q <= 1'b0;
        if (valid_i && full && !guard_q) ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxeb_rd_ctl.sv
`timescale 1ns/1ps
module rxeb_rd_ctl
  import rxeb_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          resync_i,
  input  logic [AW-1:0] delay_i,
  input  logic [AW:0]   wr_gray_i,
  input  logic          ack_tgl_i,
  input  logic          ovf_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rd_gray_o,
  output logic          req_tgl_o,
  output logic          valid_o,
  output logic          err_o
);
  localparam int PW = AW + 1;

  rd_state_e     state_q;
  logic [PW-1:0] ptr_q, ptr_n, wr_bin, occ;
  logic [AW-1:0] dly_q;
  logic          ack_q, empty;

  always_comb begin
    for (int i = 0; i < PW; i++) wr_bin[i] = ^(wr_gray_i >> i);
  end

  assign occ     = wr_bin - ptr_q;
  assign empty   = (occ == '0);
  assign re_o    = (state_q == RD_RUN) && !resync_i && !empty;
  assign raddr_o = ptr_q[AW-1:0];

  always_comb begin
    ptr_n = ptr_q;
    if (resync_i)  ptr_n = '0;
    else if (re_o) ptr_n = ptr_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RD_FILL;
      ptr_q     <= '0;
      rd_gray_o <= '0;
      dly_q     <= '0;
      req_tgl_o <= 1'b0;
      ack_q     <= 1'b0;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      ptr_q     <= ptr_n;
      rd_gray_o <= ptr_n ^ (ptr_n >> 1);
      ack_q     <= ack_tgl_i;
      valid_o   <= 1'b0;
      if (resync_i) begin
        dly_q     <= delay_i;
        req_tgl_o <= ~req_tgl_o;
        state_q   <= RD_WAIT;
        err_o     <= 1'b0;
      end else begin
        case (state_q)
          RD_WAIT: if (ack_tgl_i != ack_q) state_q <= RD_FILL;
          RD_FILL: if (!empty && occ >= {1'b0, dly_q}) state_q <= RD_RUN;
          RD_RUN: begin
            if (empty || ovf_i) err_o <= 1'b1;
            valid_o <= !empty && !err_o && !ovf_i;
          end
          default: state_q <= RD_FILL;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_elastic_buf.sv
`timescale 1ns/1ps
module rx_elastic_buf #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] delay_i,
  input  logic          resync_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          err_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic          req_tgl, req_tgl_s, ack_tgl, ack_tgl_s, ovf, ovf_s;
  logic          we, re, wr_restart;
  logic [AW-1:0] waddr, raddr;

  rxeb_sync #(.W(PW + 2)) u_to_rd (
    .clk_i (rd_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_gray, ack_tgl, ovf}),
    .q_o   ({wr_gray_s, ack_tgl_s, ovf_s})
  );

  rxeb_sync #(.W(PW + 1)) u_to_wr (
    .clk_i (wr_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rd_gray, req_tgl}),
    .q_o   ({rd_gray_s, req_tgl_s})
  );

  rxeb_wr_ctl #(.AW(AW)) u_wr (
    .clk_i    (wr_clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (wr_valid_i),
    .req_tgl_i(req_tgl_s),
    .rd_gray_i(rd_gray_s),
    .we_o     (we),
    .waddr_o  (waddr),
    .wr_gray_o(wr_gray),
    .ack_tgl_o(ack_tgl),
    .ovf_o    (ovf),
    .restart_o(wr_restart)
  );

  rxeb_rd_ctl #(.AW(AW)) u_rd (
    .clk_i    (rd_clk_i),
    .rst_ni   (rst_ni),
    .resync_i (resync_i),
    .delay_i  (delay_i),
    .wr_gray_i(wr_gray_s),
    .ack_tgl_i(ack_tgl_s),
    .ovf_i    (ovf_s),
    .re_o     (re),
    .raddr_o  (raddr),
    .rd_gray_o(rd_gray),
    .req_tgl_o(req_tgl),
    .valid_o  (rd_valid_o),
    .err_o    (err_o)
  );

  rxeb_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk_i (wr_clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .rclk_i (rd_clk_i),
    .rst_ni (rst_ni),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/rxeb_checker.sv
`timescale 1ns/1ps
module rxeb_checker #(
  parameter int AW = 4
) (
  input logic        wr_clk_i,
  input logic        rd_clk_i,
  input logic        rst_ni,
  input logic        resync_i,
  input logic        rd_valid_o,
  input logic        err_o,
  input logic [AW:0] wr_gray_i,
  input logic [AW:0] rd_gray_i,
  input logic        wr_restart_i
);
  assert_no_valid_after_resync_R4: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni) resync_i |=> !rd_valid_o);

  assert_err_sticky_R5: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni) (err_o && !resync_i) |=> err_o);

  assert_err_blocks_valid_R5: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni) err_o |=> !rd_valid_o);

  assert_resync_clears_err_R7: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni) resync_i |=> !err_o);

  assert_wr_gray_step_R9: assert property (
    @(posedge wr_clk_i) disable iff (!rst_ni)
    !$past(wr_restart_i) |-> ($countones(wr_gray_i ^ $past(wr_gray_i)) <= 1));

  assert_rd_gray_step_R9: assert property (
    @(posedge rd_clk_i) disable iff (!rst_ni)
    !$past(resync_i) |-> ($countones(rd_gray_i ^ $past(rd_gray_i)) <= 1));
endmodule

bind rx_elastic_buf rxeb_checker #(.AW(AW)) u_chk (
  .wr_clk_i    (wr_clk_i),
  .rd_clk_i    (rd_clk_i),
  .rst_ni      (rst_ni),
  .resync_i    (resync_i),
  .rd_valid_o  (rd_valid_o),
  .err_o       (err_o),
  .wr_gray_i   (wr_gray),
  .rd_gray_i   (rd_gray),
  .wr_restart_i(wr_restart)
);

// File: tb/sim_rx_elastic_buf.sv
`timescale 1ns/1ps
module sim_rx_elastic_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  realtime       wr_half = 5.0;
  logic          wr_valid = 1'b0, wr_en = 1'b0, resync = 1'b0;
  logic [DW-1:0] wr_data = '0, seq = '0;
  logic [AW-1:0] delay = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, err;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] prev = '0;
  bit have_prev = 1'b0;
  int n_valid = 0, n_gap = 0, last_lag = 0;

  rx_elastic_buf #(.AW(AW), .DW(DW)) u0 (
    .wr_clk_i  (wr_clk),
    .rd_clk_i  (rd_clk),
    .rst_ni    (rst_n),
    .wr_valid_i(wr_valid),
    .wr_data_i (wr_data),
    .delay_i   (delay),
    .resync_i  (resync),
    .rd_data_o (rd_data),
    .rd_valid_o(rd_valid),
    .err_o     (err)
  );

  initial forever #(CLK_PERIOD / 2) rd_clk = ~rd_clk;
  initial begin
    #3;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  // write source: consecutive sequence numbers
  initial begin
    forever begin
      @(negedge wr_clk);
      if (wr_en) begin
        wr_valid = 1'b1;
        wr_data  = seq;
        seq      = seq + 1'b1;
      end else begin
        wr_valid = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cur_lag();
    logic [DW-1:0] d;
    d = seq - 1'b1 - rd_data;
    return int'(d);
  endfunction

  task automatic clr_mon();
    have_prev = 1'b0;
    n_valid   = 0;
    n_gap     = 0;
  endtask

  task automatic run_rd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      if (rd_valid) begin
        if (have_prev && rd_data != DW'(prev + 1'b1)) n_gap++;
        prev      = rd_data;
        have_prev = 1'b1;
        n_valid++;
        last_lag  = cur_lag();
      end
    end
  endtask

  task automatic do_resync(input logic [AW-1:0] d, output int lag0);
    int w;
    @(negedge rd_clk);
    delay  = d;
    resync = 1'b1;
    @(negedge rd_clk);
    resync = 1'b0;
    chk(rd_valid == 1'b0, "R4 valid after resync", int'(rd_valid), 0);
    chk(err == 1'b0, "R7 err cleared by resync", int'(err), 0);
    clr_mon();
    w = 0;
    while (!rd_valid && w < 200) begin
      @(negedge rd_clk);
      w++;
    end
    chk(rd_valid == 1'b1, "R4 stream released", int'(rd_valid), 1);
    lag0      = cur_lag();
    prev      = rd_data;
    have_prev = 1'b1;
    n_valid   = 1;
    last_lag  = lag0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge rd_clk);
    chk(rd_valid == 1'b0, "R1 valid in reset", int'(rd_valid), 0);
    chk(err == 1'b0, "R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    chk(rd_valid == 1'b0, "R1 valid with no data", int'(rd_valid), 0);
  endtask

  task automatic t_stream();
    clr_mon();
    wr_en = 1'b1;
    run_rd(60);
    chk(n_valid >= 50, "R1 R2 stream starts at reset delay", n_valid, 50);
    chk(n_gap == 0, "R2 R9 order", n_gap, 0);
    chk(err == 1'b0, "R2 no error", int'(err), 0);
  endtask

  task automatic t_delay_hold();
    int base;
    base  = last_lag;
    delay = 4'd8;
    clr_mon();
    run_rd(40);
    chk(last_lag == base, "R3 delay ignored before resync", last_lag, base);
    chk(n_valid == 40 && n_gap == 0, "R3 stream undisturbed", n_valid, 40);
  endtask

  task automatic t_resync_delay();
    int l8, l2;
    do_resync(4'd8, l8);
    chk(l8 >= 8 && l8 <= 16, "R4 lag at release, delay 8", l8, 8);
    run_rd(40);
    chk(n_gap == 0 && n_valid == 41, "R2 stream after resync", n_valid, 41);
    l8 = last_lag;
    do_resync(4'd2, l2);
    chk(l2 >= 2 && l2 <= 10, "R4 lag at release, delay 2", l2, 2);
    run_rd(40);
    l2 = last_lag;
    chk(l8 - l2 >= 5 && l8 - l2 <= 7, "R3 lag difference", l8 - l2, 6);
  endtask

  task automatic t_underflow();
    wr_en = 1'b0;
    run_rd(30);
    chk(err == 1'b1, "R5 underflow flag", int'(err), 1);
    chk(rd_valid == 1'b0, "R5 valid low", int'(rd_valid), 0);
    wr_en = 1'b1;
    clr_mon();
    run_rd(40);
    chk(n_valid == 0, "R5 data masked after refill", n_valid, 0);
    chk(err == 1'b1, "R5 flag sticky", int'(err), 1);
  endtask

  task automatic t_recover();
    int l;
    do_resync(4'd4, l);
    run_rd(40);
    chk(n_gap == 0 && n_valid == 41, "R7 stream restarts", n_valid, 41);
    chk(err == 1'b0, "R7 err stays clear", int'(err), 0);
  endtask

  task automatic t_overflow();
    int l, nv;
    clr_mon();
    wr_half = 3.0;
    run_rd(150);
    chk(err == 1'b1, "R6 overflow flag", int'(err), 1);
    chk(n_gap == 0, "R6 no gap leaves buffer", n_gap, 0);
    wr_half = 5.0;
    nv = n_valid;
    run_rd(10);
    chk(n_valid == nv, "R6 no valid after overflow", n_valid, nv);
    do_resync(4'd2, l);
    chk(l >= 2 && l <= 10, "R8 lag after rate change", l, 2);
    run_rd(40);
    chk(n_gap == 0 && n_valid == 41, "R8 stream after rate change", n_valid, 41);
    chk(err == 1'b0, "R8 no error", int'(err), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stream();
    t_delay_hold();
    t_resync_delay();
    t_underflow();
    t_recover();
    t_overflow();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule